// File: doc/BRIEF.md
# Cluster Coherence Directory Controller

This block sits on the network side of one cluster in a clustered shared-memory machine. It tracks which lines of this cluster's local memory are held in the caches of other clusters. Each tracked line has a small table slot with a line tag, a sharing mode (Shared or Exclusive) and a bit per cluster that holds a copy. Every memory request, whether it comes from a remote cluster or from the home cluster, is looked up in that table. The controller then sends any invalidate or fetch-back messages the request needs, collects the acknowledgements, updates the slot and answers the requester.

Requests are handled one at a time. Outgoing coherence messages are issued one per valid/ready handshake, and each one names a destination cluster. Acknowledgements return on their own valid/ready port and carry the responding cluster's ID. The response is a single bit that says whether the request completed or must be retried because no slot was free. The home cluster has the ID given by `HOME_ID`. It never takes a sharer bit, because its accesses go to local memory directly.

Top module: `dir_ctl`

## Requirements
- R1: After reset `req_ready` is 1, `msg_valid`, `rsp_valid` and `ack_ready` are 0, and no line is tracked.
- R2: From the cycle a request is accepted until its response is taken (`rsp_valid` and `rsp_ready`), `req_ready` stays 0. `rsp_valid` stays high while `rsp_ready` is 0.
- R3: A request that needs no coherence message is answered with `rsp_retry`=0 in the cycle after it is accepted.
- R4: A read from a remote cluster adds the requester to the line's sharer set. On a miss it allocates a slot in Shared mode with only the requester set.
- R5: A write by cluster X to a Shared line sends one invalidate (`msg_fetch`=0) to every sharer other than X, one per handshake, in ascending cluster ID. The line then becomes Exclusive with X as the only holder.
- R6: The response comes in the cycle after the last outstanding acknowledgement is accepted. With m messages each acknowledged one cycle after its handshake, it comes m+2 cycles after acceptance.
- R7: Any request to an Exclusive line from a cluster other than its owner first sends exactly one fetch-back message (`msg_fetch`=1) to the owner.
- R8: A remote read of an Exclusive line, once the line is fetched back, leaves it Shared with both the old owner and the reader set.
- R9: A remote write to a line held elsewhere leaves it Exclusive to the writer. A write by the home cluster empties the sharer set and frees the slot. The home cluster is never added to a sharer set.
- R10: A remote request that misses while all `ENTRIES` slots are in use is answered with `rsp_retry`=1 in the cycle after acceptance, sends no message and changes no slot. A home-cluster miss never needs a slot and is never retried.
- R11: A slot freed under R9 can be allocated again by a later miss.
- R12: A request from the cluster that holds the line Exclusive sends no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Line address of the request |
| req_src | input | CW | Requesting cluster ID |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_retry | output | 1 | 1 = no free slot, retry; 0 = done |
| msg_valid | output | 1 | Coherence message present |
| msg_ready | input | 1 | Network accepts the message |
| msg_fetch | output | 1 | 1 = fetch back the modified line, 0 = invalidate |
| msg_dst | output | CW | Destination cluster ID |
| msg_addr | output | AW | Line address of the message |
| ack_valid | input | 1 | Acknowledgement present |
| ack_ready | output | 1 | Acknowledgements accepted (transaction outstanding) |
| ack_src | input | CW | Cluster sending the acknowledgement |

## Verification
Each result has a fixed due cycle counted from the accepting clock edge. A response that needs no messages is due one cycle later. The k-th message of a transaction appears k cycles after acceptance, and the response follows one cycle after the last acknowledgement is accepted. The bench drives and samples on the falling edge. It acknowledges each message on the cycle after its handshake, so it can predict the response cycle as 1 or m+2 from the expected sharer mask alone. At each falling edge it records the destination, the message kind and the state of `req_ready`, and then compares the count of the edge where `rsp_valid` first shows against that prediction.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } ctl_state_e;

  // index of the lowest set bit (0 when none is set)
  function automatic int unsigned lowest_set(input logic [63:0] v);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // one-hot bit for a cluster, or zero when the cluster takes no sharer bit
  function automatic logic [63:0] cluster_bit(input int unsigned id, input logic en);
    return en ? (64'd1 << id) : 64'd0;
  endfunction

endpackage

// File: rtl/dir_table.sv
module dir_table #(
  parameter int ENTRIES = 4,
  parameter int AW      = 16,
  parameter int NCLUS   = 8,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    lk_addr,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output logic             hit_excl,
  output logic [NCLUS-1:0] hit_sharers,
  output logic             free_ok,
  output logic [IW-1:0]    free_idx,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_tag,
  input  logic             wr_excl,
  input  logic [NCLUS-1:0] wr_sharers
);

  logic             vld_q  [ENTRIES];
  logic [AW-1:0]    tag_q  [ENTRIES];
  logic             excl_q [ENTRIES];
  logic [NCLUS-1:0] shr_q  [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        tag_q[g]  <= '0;
        excl_q[g] <= 1'b0;
        shr_q[g]  <= '0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        vld_q[g]  <= wr_valid;
        tag_q[g]  <= wr_tag;
        excl_q[g] <= wr_excl;
        shr_q[g]  <= wr_valid ? wr_sharers : '0;
      end
    end
    assign match[g] = vld_q[g] && (tag_q[g] == lk_addr);
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx = IW'(i);
    end
  end

  assign hit_excl    = excl_q[hit_idx];
  assign hit_sharers = shr_q[hit_idx];

  // lowest free slot wins
  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_ok  = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/dir_policy.sv
module dir_policy
  import dir_pkg::*;
#(
  parameter int NCLUS   = 8,
  parameter int CW      = 3,
  parameter int HOME_ID = 0
) (
  input  logic             is_write,
  input  logic [CW-1:0]    src,
  input  logic             hit,
  input  logic             hit_excl,
  input  logic [NCLUS-1:0] hit_sharers,
  input  logic             free_ok,
  output logic             retry,
  output logic             upd,
  output logic             upd_alloc,
  output logic             nxt_valid,
  output logic             nxt_excl,
  output logic [NCLUS-1:0] nxt_sharers,
  output logic [NCLUS-1:0] targets,
  output logic             fetch
);

  logic             remote;
  logic [NCLUS-1:0] src_bit;

  assign remote  = (src != CW'(HOME_ID));
  assign src_bit = NCLUS'(cluster_bit(int'(src), remote));

  always_comb begin
    retry       = 1'b0;
    upd         = 1'b0;
    upd_alloc   = 1'b0;
    nxt_valid   = 1'b1;
    nxt_excl    = hit_excl;
    nxt_sharers = hit_sharers;
    targets     = '0;
    fetch       = 1'b0;
    if (!hit) begin
      // home accesses need no slot; remote ones allocate
      if (remote) begin
        if (!free_ok) begin
          retry = 1'b1;
        end else begin
          upd         = 1'b1;
          upd_alloc   = 1'b1;
          nxt_excl    = is_write;
          nxt_sharers = src_bit;
        end
      end
    end else if (!hit_excl) begin
      upd = 1'b1;
      if (!is_write) begin
        nxt_sharers = hit_sharers | src_bit;
      end else begin
        targets     = hit_sharers & ~src_bit;
        nxt_excl    = 1'b1;
        nxt_sharers = src_bit;
        nxt_valid   = remote;
      end
    end else if ((hit_sharers & src_bit) == '0) begin
      // held exclusively elsewhere: pull it back first
      upd     = 1'b1;
      fetch   = 1'b1;
      targets = hit_sharers;
      if (!is_write) begin
        nxt_excl    = 1'b0;
        nxt_sharers = hit_sharers | src_bit;
      end else begin
        nxt_excl    = 1'b1;
        nxt_sharers = src_bit;
        nxt_valid   = remote;
      end
    end
  end

endmodule

// File: rtl/dir_sender.sv
module dir_sender
  import dir_pkg::*;
#(
  parameter int NCLUS = 8,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NCLUS-1:0] load_mask,
  input  logic             send_en,
  input  logic             ack_en,
  input  logic             msg_ready,
  input  logic             ack_valid,
  input  logic [CW-1:0]    ack_src,
  output logic             have_send,
  output logic [CW-1:0]    dst,
  output logic             fire,
  output logic             sends_left,
  output logic             all_clear,
  output logic             await_empty
);

  logic [NCLUS-1:0] to_send_q, to_send_d;
  logic [NCLUS-1:0] await_q, await_d;
  logic [NCLUS-1:0] dst_bit, ack_bit;
  logic             ack_hit;

  assign dst       = CW'(lowest_set(64'(to_send_q)));
  assign have_send = |to_send_q;
  assign dst_bit   = NCLUS'(cluster_bit(int'(dst), have_send));
  assign fire      = send_en && have_send && msg_ready;
  assign ack_hit   = ack_en && ack_valid && await_q[ack_src];
  assign ack_bit   = NCLUS'(cluster_bit(int'(ack_src), ack_hit));

  always_comb begin
    if (load) begin
      to_send_d = load_mask;
      await_d   = '0;
    end else begin
      to_send_d = fire ? (to_send_q & ~dst_bit) : to_send_q;
      await_d   = (await_q & ~ack_bit) | (fire ? dst_bit : '0);
    end
  end

  assign sends_left  = |to_send_d;
  assign all_clear   = (to_send_d == '0) && (await_d == '0);
  assign await_empty = (await_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_send_q <= '0;
      await_q   <= '0;
    end else begin
      to_send_q <= to_send_d;
      await_q   <= await_d;
    end
  end

endmodule

// File: rtl/dir_ctl.sv
module dir_ctl
  import dir_pkg::*;
#(
  parameter int NCLUS   = 8,
  parameter int ENTRIES = 4,
  parameter int AW      = 16,
  parameter int HOME_ID = 0,
  localparam int CW     = (NCLUS > 1) ? $clog2(NCLUS) : 1,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_src,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_retry,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic          msg_fetch,
  output logic [CW-1:0] msg_dst,
  output logic [AW-1:0] msg_addr,
  input  logic          ack_valid,
  output logic          ack_ready,
  input  logic [CW-1:0] ack_src
);

  ctl_state_e state_q, state_d;

  // lookup results
  logic             hit, hit_excl, free_ok;
  logic [IW-1:0]    hit_idx, free_idx;
  logic [NCLUS-1:0] hit_sharers;

  // policy results
  logic             pol_retry, pol_upd, pol_alloc, pol_valid, pol_excl, pol_fetch;
  logic [NCLUS-1:0] pol_sharers, pol_targets;

  // captured transaction
  logic [AW-1:0]    addr_q;
  logic [CW-1:0]    src_q;
  logic             retry_q, fetch_q, pend_upd_q, pend_valid_q, pend_excl_q;
  logic [IW-1:0]    pend_idx_q;
  logic [NCLUS-1:0] pend_shr_q;

  // named events
  logic accept, commit, retry_taken, msg_fire;
  logic have_send, sends_left, all_clear, await_empty;

  assign accept      = req_valid && req_ready;
  assign commit      = (state_q == ST_RESP) && pend_upd_q;
  assign retry_taken = accept && pol_retry;

  dir_table #(.ENTRIES(ENTRIES), .AW(AW), .NCLUS(NCLUS)) u_table (
    .clk(clk), .rst_n(rst_n), .lk_addr(req_addr),
    .hit(hit), .hit_idx(hit_idx), .hit_excl(hit_excl), .hit_sharers(hit_sharers),
    .free_ok(free_ok), .free_idx(free_idx),
    .wr_en(commit), .wr_idx(pend_idx_q), .wr_valid(pend_valid_q),
    .wr_tag(addr_q), .wr_excl(pend_excl_q), .wr_sharers(pend_shr_q)
  );

  dir_policy #(.NCLUS(NCLUS), .CW(CW), .HOME_ID(HOME_ID)) u_policy (
    .is_write(req_write), .src(req_src),
    .hit(hit), .hit_excl(hit_excl), .hit_sharers(hit_sharers), .free_ok(free_ok),
    .retry(pol_retry), .upd(pol_upd), .upd_alloc(pol_alloc),
    .nxt_valid(pol_valid), .nxt_excl(pol_excl), .nxt_sharers(pol_sharers),
    .targets(pol_targets), .fetch(pol_fetch)
  );

  dir_sender #(.NCLUS(NCLUS), .CW(CW)) u_sender (
    .clk(clk), .rst_n(rst_n),
    .load(accept && !pol_retry), .load_mask(pol_targets),
    .send_en(state_q == ST_SEND),
    .ack_en((state_q == ST_SEND) || (state_q == ST_WAIT)),
    .msg_ready(msg_ready), .ack_valid(ack_valid), .ack_src(ack_src),
    .have_send(have_send), .dst(msg_dst), .fire(msg_fire),
    .sends_left(sends_left), .all_clear(all_clear), .await_empty(await_empty)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = (pol_retry || (pol_targets == '0)) ? ST_RESP : ST_SEND;
      ST_SEND: begin
        if (all_clear)        state_d = ST_RESP;
        else if (!sends_left) state_d = ST_WAIT;
      end
      ST_WAIT: if (all_clear) state_d = ST_RESP;
      ST_RESP: if (rsp_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      src_q        <= '0;
      retry_q      <= 1'b0;
      fetch_q      <= 1'b0;
      pend_upd_q   <= 1'b0;
      pend_idx_q   <= '0;
      pend_valid_q <= 1'b0;
      pend_excl_q  <= 1'b0;
      pend_shr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q       <= req_addr;
        src_q        <= req_src;
        retry_q      <= pol_retry;
        fetch_q      <= pol_fetch;
        pend_upd_q   <= pol_upd;
        pend_idx_q   <= pol_alloc ? free_idx : hit_idx;
        pend_valid_q <= pol_valid;
        pend_excl_q  <= pol_excl;
        pend_shr_q   <= pol_sharers;
      end else if (commit) begin
        pend_upd_q <= 1'b0;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_retry = retry_q;
  assign msg_valid = (state_q == ST_SEND) && have_send;
  assign msg_fetch = fetch_q;
  assign msg_addr  = addr_q;
  assign ack_ready = (state_q == ST_SEND) || (state_q == ST_WAIT);

endmodule

// File: rtl/dir_ctl_checker.sv
module dir_ctl_checker #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          accept,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic          msg_fire,
  input logic          msg_fetch,
  input logic [CW-1:0] msg_dst,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_retry,
  input logic          retry_taken,
  input logic          await_empty,
  input logic [CW-1:0] src_q
);

  assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, msg_valid, rsp_valid}));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_rsp_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_retry));

  assert_msg_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_dst) && $stable(msg_fetch));

  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_fire |=> (!msg_valid || (msg_dst > $past(msg_dst))));

  assert_acks_before_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> await_empty);

  assert_single_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_fire && msg_fetch) |=> !msg_valid);

  assert_retry_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retry_taken |=> rsp_valid && rsp_retry && !msg_valid);

  assert_no_self_msg_R12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_dst != src_q));

endmodule

bind dir_ctl dir_ctl_checker #(.CW(CW)) u_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .accept(accept),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_fire(msg_fire),
  .msg_fetch(msg_fetch), .msg_dst(msg_dst),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_retry(rsp_retry),
  .retry_taken(retry_taken), .await_empty(await_empty), .src_q(src_q)
);

// File: tb/dir_ctl_bench.sv
module dir_ctl_bench;

  localparam int NC = 8;
  localparam int AW = 16;
  localparam int CW = 3;
  localparam int NV = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_src = '0;
  logic          rsp_ready = 1'b1, msg_ready = 1'b1, ack_valid = 1'b0;
  logic [CW-1:0] ack_src = '0;
  logic          req_ready, rsp_valid, rsp_retry, msg_valid, msg_fetch, ack_ready;
  logic [CW-1:0] msg_dst;
  logic [AW-1:0] msg_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dir_ctl #(.NCLUS(NC), .ENTRIES(4), .AW(AW), .HOME_ID(0)) u_dir_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_src(req_src),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_retry(rsp_retry),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_fetch(msg_fetch),
    .msg_dst(msg_dst), .msg_addr(msg_addr),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_src(ack_src)
  );

  // vector: {write, addr[15:0], src[2:0], exp_retry, exp_targets[7:0], exp_fetch}
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 16'h0010, 3'd3, 1'b0, 8'h00, 1'b0}, // R4 miss alloc {3}
    {1'b0, 16'h0010, 3'd5, 1'b0, 8'h00, 1'b0}, // R4 {3,5}
    {1'b0, 16'h0010, 3'd1, 1'b0, 8'h00, 1'b0}, // R4 {1,3,5}
    {1'b1, 16'h0010, 3'd3, 1'b0, 8'h22, 1'b0}, // R5 inv 1,5 -> excl 3
    {1'b1, 16'h0010, 3'd3, 1'b0, 8'h00, 1'b0}, // R12 owner writes
    {1'b0, 16'h0010, 3'd6, 1'b0, 8'h08, 1'b1}, // R7 fetch 3 -> shared {3,6}
    {1'b1, 16'h0010, 3'd2, 1'b0, 8'h48, 1'b0}, // R8 inv 3,6 -> excl 2
    {1'b1, 16'h0010, 3'd0, 1'b0, 8'h04, 1'b1}, // R9 home write frees
    {1'b1, 16'h0010, 3'd4, 1'b0, 8'h00, 1'b0}, // R9 freed: new excl {4}
    {1'b0, 16'h0020, 3'd1, 1'b0, 8'h00, 1'b0},
    {1'b0, 16'h0030, 3'd1, 1'b0, 8'h00, 1'b0},
    {1'b0, 16'h0040, 3'd1, 1'b0, 8'h00, 1'b0}, // table full
    {1'b0, 16'h0050, 3'd2, 1'b1, 8'h00, 1'b0}, // R10 retry
    {1'b0, 16'h0050, 3'd0, 1'b0, 8'h00, 1'b0}, // R10 home miss ok
    {1'b1, 16'h0020, 3'd0, 1'b0, 8'h02, 1'b0}, // R9 home write frees slot
    {1'b0, 16'h0050, 3'd2, 1'b0, 8'h00, 1'b0}, // R11 slot reused
    {1'b1, 16'h0050, 3'd7, 1'b0, 8'h04, 1'b0}, // R5 inv 2 -> excl 7
    {1'b0, 16'h0010, 3'd0, 1'b0, 8'h10, 1'b1}, // R7 home read fetches 4
    {1'b1, 16'h0010, 3'd5, 1'b0, 8'h10, 1'b0}  // R9 home not a sharer
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic w, input logic [AW-1:0] a, input logic [CW-1:0] s,
                        input logic ex_retry, input logic [NC-1:0] ex_mask,
                        input logic ex_fetch);
    logic [NC-1:0] seen;
    logic [CW-1:0] last_dst, pdst;
    logic pend, got, got_retry, order_ok, kind_ok, rdy_ok;
    int n, lat, m, exp_lat;
    seen = '0; last_dst = '0; pdst = '0; pend = 1'b0; got = 1'b0; got_retry = 1'b0;
    order_ok = 1'b1; kind_ok = 1'b1; rdy_ok = 1'b1; n = 0; lat = 0; m = 0;
    for (int i = 0; i < NC; i++) m += int'(ex_mask[i]);
    exp_lat = (m == 0) ? 1 : m + 2;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_src = s;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got && n < 100) begin
      n++;
      if (rsp_valid) begin
        got = 1'b1; lat = n; got_retry = rsp_retry;
      end else if (req_ready) begin
        rdy_ok = 1'b0;
      end
      ack_valid = pend; ack_src = pdst;
      if (msg_valid) begin
        if (seen != '0 && msg_dst <= last_dst) order_ok = 1'b0;
        if (msg_fetch != ex_fetch || msg_addr != a) kind_ok = 1'b0;
        seen = seen | (NC'(1) << msg_dst);
        last_dst = msg_dst; pend = 1'b1; pdst = msg_dst;
      end else begin
        pend = 1'b0;
      end
      if (!got) @(negedge clk);
    end
    ack_valid = 1'b0;
    check(got_retry == ex_retry, ex_retry ? "R10" : "R3", "retry flag",
          int'(got_retry), int'(ex_retry));
    check(seen == ex_mask && order_ok, ex_fetch ? "R7" : "R5", "message targets",
          int'(seen), int'(ex_mask));
    check(kind_ok, ex_fetch ? "R7" : "R5", "message kind/address",
          int'(kind_ok), 1);
    check(lat == exp_lat, (m == 0) ? "R3" : "R6", "response latency", lat, exp_lat);
    check(rdy_ok, "R2", "req_ready low while busy", int'(rdy_ok), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(msg_valid == 1'b0 && rsp_valid == 1'b0, "R1", "msg/rsp after reset",
          int'({msg_valid, rsp_valid}), 0);
    check(ack_ready == 1'b0, "R1", "ack_ready after reset", int'(ack_ready), 0);

    for (int v = 0; v < NV; v++) begin
      do_req(VEC[v][29], VEC[v][28:13], VEC[v][12:10], VEC[v][9], VEC[v][8:1], VEC[v][0]);
    end

    // R2: response held while the requester stalls it
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0077; req_src = 3'd0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b1 && req_ready == 1'b0, "R2", "stalled response held",
          int'({rsp_valid, req_ready}), 2);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R2", "idle after response taken",
          int'({rsp_valid, req_ready}), 1);

    // R1: a fresh reset forgets every tracked line
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_req(1'b1, 16'h0010, 3'd6, 1'b0, 8'h00, 1'b0); // R1 no stale owner

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule